// File: doc/BRIEF.md
# Reset, Halt and Wake-up Controller

This block decides when a small processor core may execute. It covers power-up and the external reset pin. It handles watchdog expiry, which gives a full (cold) restart when the core is running and a light (warm) restart when the core is halted. It also handles entry into the low-power halt state and the return from it, triggered by a port pin change or a new interrupt request. Every restart passes through a start-up wait of 2^SST_W system cycles (1024 by default). During that wait the core-run enable stays low.

Two status bits record why the last restart happened. The timeout bit is set by watchdog expiry. The power-down bit is set by halt and cleared by power-up and by a watchdog clear. When the core leaves halt because of a pin or an interrupt, the block gives one decision at the moment the core starts again. Either the core takes the interrupt, or it resumes at the next instruction. The core, the watchdog counter and the oscillator are outside this block.

Top module: `rhw_ctrl`

## Requirements
- R1: After power-up, after a watchdog restart, after external reset release and after any halt wake-up, core_run stays low for exactly 2^SST_W rising edges, counted from the edge at which the start-up wait begins, and rises on the last of those edges.
- R2: While por_n is low, cold_rst is high, core_run is low, and to_flag and pd_flag are 0. A wdt_clr_req pulse while running clears pd_flag on the next edge.
- R3: A halt_req pulse while running sets pd_flag and drops core_run on the next edge.
- R4: A wdt_tmo pulse while running gives a one-cycle cold_rst on the next edge and sets to_flag, leaving pd_flag unchanged. The start-up wait begins at that edge.
- R5: A wdt_tmo pulse while halted gives a one-cycle warm_rst and no cold_rst on the next edge, with to_flag=1 and pd_flag=1. The later restart raises neither wake_take_irq nor wake_resume.
- R6: ext_rst_n (active low) passes through two synchronizer flops, so it acts on the third edge after it changes. Entry gives a one-cycle cold_rst. Entry from running leaves both flags unchanged, and entry from halt gives to_flag=0 and pd_flag=1. The start-up count stays at zero while the pin is low and begins on the third edge after release.
- R7: While halted, a change on a synchronized port pin whose port_wake_en bit is 1, compared with the value latched at halt entry, starts the wake-up on the third edge after the pin changes. Changes on pins whose enable bit is 0 do not wake the core.
- R8: A pin wake-up ends with a one-cycle wake_resume pulse, and wake_take_irq stays 0, on the edge where core_run rises.
- R9: An interrupt wake-up starts on the first edge after a new request flag. It ends with wake_take_irq when that request's irq_en bit is 1 and stack_full is 0. Otherwise it ends with wake_resume.
- R10: A request flag that is already 1 when halt is entered cannot wake the core.
- R11: When wdt_tmo and a wake-up event occur in the same cycle while halted, the watchdog path wins: warm_rst, to_flag=1, and no take or resume pulse afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdt_tmo | input | 1 | Watchdog expiry pulse |
| halt_req | input | 1 | Halt instruction executed |
| wdt_clr_req | input | 1 | Watchdog clear instruction executed |
| port_pin | input | NPORT | Port pins usable as wake sources |
| port_wake_en | input | NPORT | Per-pin wake enable |
| irq_flag | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Per-request interrupt enable |
| stack_full | input | 1 | Return stack has no free entry |
| cold_rst | output | 1 | Full-reset strobe to the core |
| warm_rst | output | 1 | Strobe clearing only program counter and stack pointer |
| core_run | output | 1 | Core may execute |
| wake_take_irq | output | 1 | Restart pulse: enter the interrupt routine |
| wake_resume | output | 1 | Restart pulse: continue at the next instruction |
| to_flag | output | 1 | Timeout status bit |
| pd_flag | output | 1 | Power-down status bit |

## Verification
Results from halt_req, wdt_clr_req, wdt_tmo and interrupt flags are due one edge after the stimulus. Results from port pins and ext_rst_n are due three edges after it, because of the two synchronizer flops. core_run rises 2^SST_W edges after the start-up wait begins. The take or resume pulse is due on that same edge and is gone one edge later. The bench drives on falling edges and counts edges explicitly. It checks that core_run is still low one edge before the due edge and high on it. An early or late wake-up or restart therefore fails a check.

// File: rtl/rhw_pkg.sv
package rhw_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_SST  = 2'd2,
        ST_HOLD = 2'd3
    } rhw_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_NEXT = 2'd1,
        WK_IRQ  = 2'd2
    } rhw_wake_e;

endpackage

// File: rtl/rhw_sync.sv
module rhw_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = d_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync_q.s1 <= RST_VAL;
            sync_q.s2 <= RST_VAL;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q_o = sync_q.s2;
endmodule

// File: rtl/rhw_wake_eval.sv
module rhw_wake_eval #(
    parameter int unsigned NPORT = 8,
    parameter int unsigned NIRQ  = 4
) (
    input  logic [NPORT-1:0] pin_s_i,
    input  logic [NPORT-1:0] pin_lat_i,
    input  logic [NPORT-1:0] wake_en_i,
    input  logic [NIRQ-1:0]  irq_flag_i,
    input  logic [NIRQ-1:0]  irq_blk_i,
    input  logic [NIRQ-1:0]  irq_en_i,
    input  logic             stack_full_i,
    output logic             port_wake_o,
    output logic             irq_wake_o,
    output logic             irq_take_o
);
    logic [NIRQ-1:0] fresh;

    always_comb begin
        // only requests that appeared after halt entry count
        fresh       = irq_flag_i & ~irq_blk_i;
        port_wake_o = |((pin_s_i ^ pin_lat_i) & wake_en_i);
        irq_wake_o  = |fresh;
        irq_take_o  = (|(fresh & irq_en_i)) && !stack_full_i;
    end
endmodule

// File: rtl/rhw_ctrl.sv
module rhw_ctrl
    import rhw_pkg::*;
#(
    parameter int unsigned NPORT = 8,
    parameter int unsigned NIRQ  = 4,
    parameter int unsigned SST_W = 10
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst_n,
    input  logic             wdt_tmo,
    input  logic             halt_req,
    input  logic             wdt_clr_req,
    input  logic [NPORT-1:0] port_pin,
    input  logic [NPORT-1:0] port_wake_en,
    input  logic [NIRQ-1:0]  irq_flag,
    input  logic [NIRQ-1:0]  irq_en,
    input  logic             stack_full,
    output logic             cold_rst,
    output logic             warm_rst,
    output logic             core_run,
    output logic             wake_take_irq,
    output logic             wake_resume,
    output logic             to_flag,
    output logic             pd_flag
);
    localparam logic [SST_W-1:0] CNT_LAST = {SST_W{1'b1}};

    typedef struct packed {
        rhw_state_e       state;
        logic [SST_W-1:0] cnt;
        rhw_wake_e        wk;
        logic             to;
        logic             pd;
        logic             cold;
        logic             warm;
        logic             take;
        logic             resume;
        logic [NPORT-1:0] pin_lat;
        logic [NIRQ-1:0]  blk;
    } regs_t;

    regs_t d, q;

    logic             rst_s;
    logic [NPORT-1:0] pin_s;
    logic             port_wake, irq_wake, irq_take;

    rhw_sync #(.W(1), .RST_VAL(1'b1)) u_rst_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_i   (ext_rst_n),
        .q_o   (rst_s)
    );

    rhw_sync #(.W(NPORT), .RST_VAL('0)) u_pin_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_i   (port_pin),
        .q_o   (pin_s)
    );

    rhw_wake_eval #(.NPORT(NPORT), .NIRQ(NIRQ)) u_wake (
        .pin_s_i      (pin_s),
        .pin_lat_i    (q.pin_lat),
        .wake_en_i    (port_wake_en),
        .irq_flag_i   (irq_flag),
        .irq_blk_i    (q.blk),
        .irq_en_i     (irq_en),
        .stack_full_i (stack_full),
        .port_wake_o  (port_wake),
        .irq_wake_o   (irq_wake),
        .irq_take_o   (irq_take)
    );

    always_comb begin
        d        = q;
        d.cold   = 1'b0;
        d.warm   = 1'b0;
        d.take   = 1'b0;
        d.resume = 1'b0;
        if (!rst_s) begin
            // external reset: hold the timer at zero until release
            if (q.state != ST_HOLD) begin
                d.cold = 1'b1;
                if (q.state == ST_HALT) begin
                    d.to = 1'b0;
                    d.pd = 1'b1;
                end
            end
            d.state = ST_HOLD;
            d.cnt   = '0;
            d.wk    = WK_NONE;
        end else begin
            unique case (q.state)
                ST_HOLD: begin
                    d.state = ST_SST;
                    d.cnt   = '0;
                end
                ST_SST: begin
                    if (q.cnt == CNT_LAST) begin
                        d.state  = ST_RUN;
                        d.take   = (q.wk == WK_IRQ);
                        d.resume = (q.wk == WK_NEXT);
                        d.wk     = WK_NONE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (wdt_tmo) begin
                        d.to    = 1'b1;
                        d.cold  = 1'b1;
                        d.state = ST_SST;
                        d.cnt   = '0;
                    end else if (halt_req) begin
                        d.pd      = 1'b1;
                        d.state   = ST_HALT;
                        d.pin_lat = pin_s;
                        d.blk     = irq_flag;
                    end else if (wdt_clr_req) begin
                        d.pd = 1'b0;
                    end
                end
                ST_HALT: begin
                    if (wdt_tmo) begin
                        // watchdog wins over any simultaneous wake source
                        d.to    = 1'b1;
                        d.pd    = 1'b1;
                        d.warm  = 1'b1;
                        d.state = ST_SST;
                        d.cnt   = '0;
                        d.wk    = WK_NONE;
                    end else if (port_wake || irq_wake) begin
                        d.state = ST_SST;
                        d.cnt   = '0;
                        d.wk    = irq_take ? WK_IRQ : WK_NEXT;
                    end
                end
                default: d.state = ST_SST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.state   <= ST_SST;
            q.cnt     <= '0;
            q.wk      <= WK_NONE;
            q.to      <= 1'b0;
            q.pd      <= 1'b0;
            q.cold    <= 1'b1;
            q.warm    <= 1'b0;
            q.take    <= 1'b0;
            q.resume  <= 1'b0;
            q.pin_lat <= '0;
            q.blk     <= '0;
        end else begin
            q <= d;
        end
    end

    assign cold_rst      = q.cold;
    assign warm_rst      = q.warm;
    assign core_run      = (q.state == ST_RUN);
    assign wake_take_irq = q.take;
    assign wake_resume   = q.resume;
    assign to_flag       = q.to;
    assign pd_flag       = q.pd;
endmodule

// File: rtl/rhw_ctrl_chk.sv
module rhw_ctrl_chk
    import rhw_pkg::*;
#(
    parameter int unsigned SST_W = 10
) (
    input logic             clk,
    input logic             por_n,
    input logic             wdt_tmo,
    input logic             ext_rst_s,
    input logic             cold_rst,
    input logic             warm_rst,
    input logic             core_run,
    input logic             wake_take_irq,
    input logic             wake_resume,
    input logic             to_flag,
    input logic             pd_flag,
    input rhw_state_e       state_i,
    input logic [SST_W-1:0] cnt_i
);
    p_start_delay_r1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_run) |-> ($past(state_i) == ST_SST && $past(cnt_i) == {SST_W{1'b1}}));

    p_halt_pd_r3: assert property (@(posedge clk) disable iff (!por_n)
        (state_i == ST_HALT) |-> pd_flag);

    p_wdt_to_r4: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_tmo && ext_rst_s && (state_i == ST_RUN || state_i == ST_HALT)) |=> to_flag);

    p_warm_halt_r5: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst |-> ($past(state_i) == ST_HALT && !cold_rst));

    p_cold_strobe_r6: assert property (@(posedge clk) disable iff (!por_n)
        cold_rst |=> !cold_rst);

    p_outcome_run_r8: assert property (@(posedge clk) disable iff (!por_n)
        (wake_take_irq || wake_resume) |-> $rose(core_run));

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!por_n)
        !(wake_take_irq && wake_resume));
endmodule

bind rhw_ctrl rhw_ctrl_chk #(.SST_W(SST_W)) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .wdt_tmo       (wdt_tmo),
    .ext_rst_s     (rst_s),
    .cold_rst      (cold_rst),
    .warm_rst      (warm_rst),
    .core_run      (core_run),
    .wake_take_irq (wake_take_irq),
    .wake_resume   (wake_resume),
    .to_flag       (to_flag),
    .pd_flag       (pd_flag),
    .state_i       (q.state),
    .cnt_i         (q.cnt)
);

// File: tb/rhw_ctrl_bench.sv
`timescale 1ns/1ps
module rhw_ctrl_bench;
    localparam int NPORT = 8;
    localparam int NIRQ  = 4;
    localparam int SST_W = 10;
    localparam int DLY   = 1 << SST_W;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             ext_rst_n = 1'b1;
    logic             wdt_tmo = 1'b0;
    logic             halt_req = 1'b0;
    logic             wdt_clr_req = 1'b0;
    logic [NPORT-1:0] port_pin = '0;
    logic [NPORT-1:0] port_wake_en = '0;
    logic [NIRQ-1:0]  irq_flag = '0;
    logic [NIRQ-1:0]  irq_en = '0;
    logic             stack_full = 1'b0;
    logic             cold_rst, warm_rst, core_run, wake_take_irq, wake_resume, to_flag, pd_flag;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    rhw_ctrl #(.NPORT(NPORT), .NIRQ(NIRQ), .SST_W(SST_W)) u_rhw_ctrl (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_tmo(wdt_tmo),
        .halt_req(halt_req), .wdt_clr_req(wdt_clr_req), .port_pin(port_pin),
        .port_wake_en(port_wake_en), .irq_flag(irq_flag), .irq_en(irq_en),
        .stack_full(stack_full), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .core_run(core_run), .wake_take_irq(wake_take_irq), .wake_resume(wake_resume),
        .to_flag(to_flag), .pd_flag(pd_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // core_run must rise exactly on the k-th edge from now
    task automatic expect_run(input string req, input int k);
        tick(k - 1);
        check(req, "core_run one edge early", int'(core_run), 0);
        tick(1);
        check(req, "core_run on due edge", int'(core_run), 1);
    endtask

    task automatic go_halt();
        halt_req = 1'b1;
        tick(1);
        halt_req = 1'b0;
        check("R3", "pd_flag after halt", int'(pd_flag), 1);
        check("R3", "core_run after halt", int'(core_run), 0);
    endtask

    task automatic t_powerup();
        tick(2);
        check("R2", "cold_rst in reset", int'(cold_rst), 1);
        check("R2", "core_run in reset", int'(core_run), 0);
        check("R2", "to_flag in reset", int'(to_flag), 0);
        check("R2", "pd_flag in reset", int'(pd_flag), 0);
        por_n = 1'b1;
        expect_run("R1", DLY);
        check("R2", "flags after power-up", int'({to_flag, pd_flag}), 0);
    endtask

    task automatic t_port_wake();
        port_wake_en = 8'h04;
        tick(3);
        go_halt();
        port_pin[0] = ~port_pin[0];   // R7: disabled pin, must not wake
        tick(6);
        port_pin[2] = ~port_pin[2];
        expect_run("R7", 3 + DLY);
        check("R8", "wake_resume after pin wake", int'(wake_resume), 1);
        check("R8", "wake_take_irq after pin wake", int'(wake_take_irq), 0);
        tick(1);
        check("R8", "wake_resume strobe length", int'(wake_resume), 0);
        port_wake_en = '0;
    endtask

    task automatic t_irq_take();
        irq_en = 4'b0011;
        irq_flag = 4'b0010;          // R10: pending before halt
        tick(1);
        go_halt();
        tick(20);
        irq_flag = 4'b0011;
        expect_run("R10", 1 + DLY);
        check("R9", "wake_take_irq enabled request", int'(wake_take_irq), 1);
        check("R9", "wake_resume enabled request", int'(wake_resume), 0);
        irq_flag = '0;
        irq_en = '0;
    endtask

    task automatic t_irq_next(input logic en, input logic full);
        irq_en = {3'b000, en};
        stack_full = full;
        tick(1);
        go_halt();
        tick(4);
        irq_flag = 4'b0001;
        expect_run("R9", 1 + DLY);
        check("R9", "wake_resume disabled or stack full", int'(wake_resume), 1);
        check("R9", "wake_take_irq disabled or stack full", int'(wake_take_irq), 0);
        irq_flag = '0;
        irq_en = '0;
        stack_full = 1'b0;
    endtask

    task automatic t_wdt_run();
        // pd_flag is 1 from the previous halt
        wdt_tmo = 1'b1;
        tick(1);
        wdt_tmo = 1'b0;
        check("R4", "cold_rst", int'(cold_rst), 1);
        check("R4", "warm_rst", int'(warm_rst), 0);
        check("R4", "to_flag", int'(to_flag), 1);
        check("R4", "pd_flag unchanged", int'(pd_flag), 1);
        tick(1);
        check("R4", "cold_rst one cycle", int'(cold_rst), 0);
        expect_run("R1", DLY - 1);
    endtask

    task automatic t_clr();
        wdt_clr_req = 1'b1;
        tick(1);
        wdt_clr_req = 1'b0;
        check("R2", "pd_flag after clear", int'(pd_flag), 0);
    endtask

    task automatic t_wdt_halt();
        go_halt();
        tick(3);
        wdt_tmo = 1'b1;
        tick(1);
        wdt_tmo = 1'b0;
        check("R5", "warm_rst", int'(warm_rst), 1);
        check("R5", "cold_rst", int'(cold_rst), 0);
        check("R5", "flags", int'({to_flag, pd_flag}), 3);
        tick(1);
        check("R5", "warm_rst one cycle", int'(warm_rst), 0);
        expect_run("R5", DLY - 1);
        check("R5", "no outcome pulse", int'({wake_take_irq, wake_resume}), 0);
    endtask

    task automatic t_ext_run();
        t_clr();                      // to=1, pd=0 now
        ext_rst_n = 1'b0;
        tick(2);
        check("R6", "still running in sync delay", int'(core_run), 1);
        tick(1);
        check("R6", "cold_rst on entry", int'(cold_rst), 1);
        check("R6", "core_run stopped", int'(core_run), 0);
        check("R6", "flags unchanged", int'({to_flag, pd_flag}), 2);
        tick(1);
        check("R6", "cold_rst one cycle", int'(cold_rst), 0);
        tick(40);
        ext_rst_n = 1'b1;
        expect_run("R6", 3 + DLY);
    endtask

    task automatic t_ext_halt();
        go_halt();
        ext_rst_n = 1'b0;
        tick(3);
        check("R6", "cold_rst from halt", int'(cold_rst), 1);
        check("R6", "flags from halt", int'({to_flag, pd_flag}), 1);
        tick(5);
        ext_rst_n = 1'b1;
        expect_run("R6", 3 + DLY);
    endtask

    task automatic t_priority();
        irq_en = 4'b0001;
        tick(1);
        go_halt();
        tick(2);
        irq_flag = 4'b0001;
        wdt_tmo = 1'b1;
        tick(1);
        wdt_tmo = 1'b0;
        check("R11", "warm_rst wins", int'(warm_rst), 1);
        check("R11", "to_flag set", int'(to_flag), 1);
        irq_flag = '0;
        irq_en = '0;
        expect_run("R11", DLY);
        check("R11", "no outcome pulse", int'({wake_take_irq, wake_resume}), 0);
    endtask

    initial begin
        @(negedge clk);
        t_powerup();
        t_port_wake();
        t_irq_take();
        t_irq_next(1'b0, 1'b0);
        t_irq_next(1'b1, 1'b1);
        t_wdt_run();
        t_clr();
        t_wdt_halt();
        t_ext_run();
        t_ext_halt();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        errs++;
        checks++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule